// File: doc/BRIEF.md
# Bit Error Flag Signal Monitor

This block watches a recovered serial bit stream for transitions that should not be there. It raises a loss-of-signal alarm when the rate of such transitions goes past a rate chosen by the user. A double-sampling phase detector upstream delivers two samples for every bit period. One is taken at the centre of the eye. The other is taken at the boundary just before it. A bit counts as suspect when its centre sample equals the centre sample of the bit before it, yet the boundary sample between them has the opposite value. Suspect bits are counted over a fixed window of bits, and the count is compared against one of four thresholds.

The alarm rises on the bit that pushes the count past the threshold, without waiting for the window to end. It falls only after a run of complete windows in which the count stayed at or below a quarter of the threshold. The sample stream enters over a valid/ready port. `in_ready` is held high at all times, so the block never applies back-pressure. A bit period exists only on a cycle where `in_valid` is high. Cycles without `in_valid` carry no bit and change nothing. The rate select and the alarm are plain level signals. Everything runs on the bit clock, with a synchronous active-high reset.

Top module: `ber_alarm_monitor`

## Requirements
- R1: An accepted bit is an error when a previous bit has been accepted since reset, the previous bit's `in_mid` equals this bit's `in_mid`, and this bit's `in_edge` differs from its `in_mid`. The first bit after reset is never an error.
- R2: A window is 2^WIN_LOG2 accepted bits (65536 by default). The error count restarts from zero with the first bit of every window.
- R3: Threshold by `rate_sel`: 00 gives BASE_THR, 01 gives 2×BASE_THR, 10 gives 4×BASE_THR, 11 gives 8×BASE_THR. With the default BASE_THR of 32, these are 32, 64, 128 and 256 errors per window, matching rates of 0.5E-3, 1E-3, 2E-3 and 4E-3.
- R4: `los_alarm` goes high in the cycle after the accepted bit that makes the window's error count exceed the threshold, even in the middle of a window.
- R5: Once high, `los_alarm` falls in the cycle after the last bit of the RELEASE_WINDOWS-th (default 5) consecutive complete window whose count is at or below threshold/4.
- R6: A complete window whose count is above threshold/4 sets the release progress back to zero.
- R7: `rate_sel` is sampled only during reset and on the last bit of each window. A change in the middle of a window has no effect until the next window.
- R8: The error counter saturates at its all-ones value and never wraps.
- R9: After reset, `los_alarm` is low and the bit, error and release counts are zero.
- R10: `in_ready` is always high. A cycle with `in_valid` low neither counts nor moves the window, and it does not change the sample history used by R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair valid for this bit period |
| in_ready | output | 1 | Always high; no back-pressure |
| in_mid | input | 1 | Centre-of-eye sample |
| in_edge | input | 1 | Boundary sample before this bit |
| rate_sel | input | 2 | Alarm rate select (R3 encoding) |
| los_alarm | output | 1 | Loss-of-signal alarm, active high |

## Verification
The hardest state to reach from the ports is a counter that would wrap. A window has to be filled with suspect bits from its first bit to its last. After that, a run of quiet windows shows whether the full window was judged bad. The bench shrinks the window to 64 bits and the base threshold to 4, so the counter is six bits wide. It then sends a window made of errors only, right after one that already raised the alarm. It also sweeps every combination of previous centre sample, current centre sample and boundary sample, with an idle cycle carrying misleading samples placed between them.

// File: rtl/ber_pkg.sv
package ber_pkg;

  typedef enum logic [1:0] {
    RATE_X1 = 2'b00,
    RATE_X2 = 2'b01,
    RATE_X4 = 2'b10,
    RATE_X8 = 2'b11
  } rate_sel_e;

  // Threshold multiplier for a rate select code
  function automatic int unsigned rate_scale(input logic [1:0] sel);
    case (sel)
      RATE_X1: return 1;
      RATE_X2: return 2;
      RATE_X4: return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/ber_err_detect.sv
module ber_err_detect (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic mid_smp,
  input  logic edge_smp,
  output logic err_pulse
);

  logic have_prev;
  logic prev_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_mid  <= 1'b0;
    end else if (bit_valid) begin
      have_prev <= 1'b1;
      prev_mid  <= mid_smp;
    end
  end

  // Equal centre samples with a boundary sample of the other value
  always_comb begin
    err_pulse = bit_valid && have_prev &&
                (prev_mid == mid_smp) && (edge_smp != mid_smp);
  end

  // R10: idle cycles leave the history alone
  a_r10_history_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(prev_mid) && $stable(have_prev)));

  // R1: no error may be reported before any bit was seen
  a_r1_first_bit_clean: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !err_pulse);

endmodule

// File: rtl/ber_window_ctr.sv
module ber_window_ctr #(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  output logic win_last
);

  logic [WIN_LOG2-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
    end else if (bit_valid) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_comb begin
    win_last = bit_valid && (&bit_cnt);
  end

  // R2: the window closes back to its first bit
  a_r2_window_wrap: assert property (@(posedge clk) disable iff (rst)
    win_last |=> (bit_cnt == '0));

  // R10: idle cycles do not move the window
  a_r10_window_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(bit_cnt));

endmodule

// File: rtl/ber_err_accum.sv
module ber_err_accum #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             err_pulse,
  input  logic             win_last,
  output logic [CNT_W-1:0] cnt_next
);

  logic [CNT_W-1:0] err_cnt;
  logic             at_max;

  always_comb begin
    at_max   = &err_cnt;
    cnt_next = (err_pulse && !at_max) ? err_cnt + 1'b1 : err_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt <= '0;
    end else if (bit_valid) begin
      err_cnt <= win_last ? '0 : cnt_next;
    end
  end

  // R2: count restarts after the last bit of a window
  a_r2_count_restart: assert property (@(posedge clk) disable iff (rst)
    win_last |=> (err_cnt == '0));

  // R8: a full counter stays full within its window
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ((&err_cnt) && bit_valid && !win_last) |=> (&err_cnt));

endmodule

// File: rtl/ber_alarm_fsm.sv
module ber_alarm_fsm
  import ber_pkg::*;
#(
  parameter int unsigned CNT_W           = 9,
  parameter int unsigned BASE_THR        = 32,
  parameter int unsigned RELEASE_WINDOWS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             win_last,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [1:0]       rate_sel,
  output logic             alarm
);

  localparam int unsigned REL_W = $clog2(RELEASE_WINDOWS + 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RELEASE_WINDOWS - 1);

  logic [1:0]       sel_q;
  logic [REL_W-1:0] rel_cnt;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] qthr;
  logic             over_thr;
  logic             quiet;

  always_comb begin
    thr      = CNT_W'(BASE_THR * rate_scale(sel_q));
    qthr     = thr >> 2;
    over_thr = cnt_next > thr;
    quiet    = cnt_next <= qthr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= rate_sel;
      alarm   <= 1'b0;
      rel_cnt <= '0;
    end else if (bit_valid) begin
      if (win_last) begin
        sel_q <= rate_sel;
      end
      if (over_thr) begin
        alarm   <= 1'b1;
        rel_cnt <= '0;
      end else if (win_last && alarm) begin
        if (!quiet) begin
          rel_cnt <= '0;
        end else if (rel_cnt == REL_LAST) begin
          alarm   <= 1'b0;
          rel_cnt <= '0;
        end else begin
          rel_cnt <= rel_cnt + 1'b1;
        end
      end
    end
  end

  // R4: crossing the threshold raises the alarm on the next cycle
  a_r4_raise: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && over_thr) |=> alarm);

  // R5: the alarm only falls after a window boundary
  a_r5_fall_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> $past(win_last));

  // R6: a noisy window wipes the release progress
  a_r6_release_reset: assert property (@(posedge clk) disable iff (rst)
    (win_last && alarm && !quiet) |=> (rel_cnt == '0));

  // R7: the select is held inside a window
  a_r7_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !win_last |=> $stable(sel_q));

endmodule

// File: rtl/ber_alarm_monitor.sv
module ber_alarm_monitor #(
  parameter int unsigned WIN_LOG2        = 16,
  parameter int unsigned BASE_THR        = 32,
  parameter int unsigned RELEASE_WINDOWS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_mid,
  input  logic       in_edge,
  input  logic [1:0] rate_sel,
  output logic       los_alarm
);

  // Wide enough to exceed the largest threshold
  localparam int unsigned CNT_W = $clog2(BASE_THR * 8) + 1;

  logic             err_pulse;
  logic             win_last;
  logic [CNT_W-1:0] cnt_next;

  assign in_ready = 1'b1;

  ber_err_detect u_detect (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (in_valid),
    .mid_smp   (in_mid),
    .edge_smp  (in_edge),
    .err_pulse (err_pulse)
  );

  ber_window_ctr #(
    .WIN_LOG2 (WIN_LOG2)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (in_valid),
    .win_last  (win_last)
  );

  ber_err_accum #(
    .CNT_W (CNT_W)
  ) u_accum (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (in_valid),
    .err_pulse (err_pulse),
    .win_last  (win_last),
    .cnt_next  (cnt_next)
  );

  ber_alarm_fsm #(
    .CNT_W           (CNT_W),
    .BASE_THR        (BASE_THR),
    .RELEASE_WINDOWS (RELEASE_WINDOWS)
  ) u_alarm (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (in_valid),
    .win_last  (win_last),
    .cnt_next  (cnt_next),
    .rate_sel  (rate_sel),
    .alarm     (los_alarm)
  );

  // R9: alarm is clear on the first cycle out of reset
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> !los_alarm);

endmodule

// File: tb/ber_alarm_monitor_bench.sv
module ber_alarm_monitor_bench;

  localparam int WL   = 6;
  localparam int WIN  = 1 << WL;
  localparam int BASE = 4;
  localparam int RELW = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_mid = 1'b0;
  logic       in_edge = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       los_alarm;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ber_alarm_monitor #(
    .WIN_LOG2 (WL), .BASE_THR (BASE), .RELEASE_WINDOWS (RELW)
  ) u_ber_alarm_monitor (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_mid (in_mid), .in_edge (in_edge), .rate_sel (rate_sel),
    .los_alarm (los_alarm)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rate_sel = sel;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic m, input logic e);
    in_valid = 1'b1; in_mid = m; in_edge = e;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input logic m, input logic e);
    in_valid = 1'b0; in_mid = m; in_edge = e;
    @(negedge clk);
  endtask

  task automatic send_clean(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic send_err(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b1);
  endtask

  // Seed bit plus five errors, window then filled: alarm high, window closed
  task automatic raise_and_close();
    do_reset(2'b00);
    send_bit(1'b0, 1'b0);
    send_err(5);
    send_clean(WIN - 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9 reset state and R10 ready
    do_reset(2'b00);
    check(los_alarm, 1'b0, "R9 alarm low after reset");
    check(in_ready, 1'b1, "R10 ready high");

    // R1 sweep over previous mid, mid, edge; idle junk in between (R10)
    for (int c = 0; c < 8; c++) begin
      logic pm, m, e, exp_err;
      pm = c[2]; m = c[1]; e = c[0];
      exp_err = (pm == m) && (e != m);
      do_reset(2'b00);
      send_bit(1'b0, 1'b1);             // first bit: never an error
      send_err(4);
      check(los_alarm, 1'b0, "R1 first bit not counted");
      send_bit(pm, pm);                 // never an error
      idle(~pm, ~e);                    // R10: must not touch history
      send_bit(m, e);
      check(los_alarm, exp_err, "R1 R10 error rule");
    end

    // R3 threshold per select, R4 rise mid-window
    for (int s = 0; s < 4; s++) begin
      int thr;
      thr = BASE << s;
      do_reset(s[1:0]);
      send_bit(1'b0, 1'b0);
      send_err(thr);
      check(los_alarm, 1'b0, "R3 at threshold");
      send_err(1);
      check(los_alarm, 1'b1, "R3 R4 above threshold");
    end

    // R2 window restart: 4 errors at end of window 0, 4 then 1 in window 1
    do_reset(2'b00);
    send_clean(WIN - 4);
    send_err(4);
    send_err(4);
    check(los_alarm, 1'b0, "R2 count restarted");
    send_err(1);
    check(los_alarm, 1'b1, "R2 new window counts");

    // R9 reset clears a raised alarm and the count
    do_reset(2'b00);
    check(los_alarm, 1'b0, "R9 reset clears alarm");
    send_bit(1'b0, 1'b0);
    send_err(4);
    check(los_alarm, 1'b0, "R9 count zero after reset");

    // R5 release after five quiet windows (quarter threshold = 1)
    raise_and_close();
    check(los_alarm, 1'b1, "R5 alarm held");
    for (int w = 0; w < RELW - 1; w++) begin send_err(1); send_clean(WIN - 1); end
    check(los_alarm, 1'b1, "R5 four quiet windows");
    send_err(1); send_clean(WIN - 2);
    check(los_alarm, 1'b1, "R5 before last bit");
    send_clean(1);
    check(los_alarm, 1'b0, "R5 released");

    // R6 noisy window (2 errors) restarts release
    raise_and_close();
    for (int w = 0; w < 2; w++) begin send_err(1); send_clean(WIN - 1); end
    send_err(2); send_clean(WIN - 2);
    for (int w = 0; w < RELW - 1; w++) send_clean(WIN);
    check(los_alarm, 1'b1, "R6 release restarted");
    send_clean(WIN);
    check(los_alarm, 1'b0, "R6 released later");

    // R8 all-error window must stay noisy (no wrap to zero)
    raise_and_close();
    send_err(WIN);
    for (int w = 0; w < RELW - 1; w++) send_clean(WIN);
    check(los_alarm, 1'b1, "R8 saturated window is noisy");
    send_clean(WIN);
    check(los_alarm, 1'b0, "R8 released after quiet run");

    // R7 select change mid-window ignored (low to high)
    do_reset(2'b00);
    send_clean(10);
    rate_sel = 2'b11;
    send_err(5);
    check(los_alarm, 1'b1, "R7 old low threshold kept");

    // R7 select change mid-window ignored (high to low), applies next window
    do_reset(2'b11);
    send_clean(10);
    rate_sel = 2'b00;
    send_err(5);
    check(los_alarm, 1'b0, "R7 old high threshold kept");
    send_clean(WIN - 15);
    send_err(5);
    check(los_alarm, 1'b1, "R7 new threshold next window");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule